// File: doc/BRIEF.md
# Stacked-Cache Channel Transaction Controller

This block sits on one channel between the last-level cache, a stack of cache sets that do their own tag matching, and main memory. Read requests and write-backs from the upper cache become set transactions in an in-order queue. The sets do not answer with a final result. They return flags (hit, dirty, a victim way), and the controller turns those flags into follow-up work. That work can be a main-memory read, an eviction read from the set, a write to main memory, or a fill write back into the set.

Every piece of work moves one 64-byte block. Each accepted request holds one buffer slot. The slot number is the transaction ID, and every command and response for that block carries it. Traffic for different blocks can therefore complete in any order. A read miss does not fill the set directly. When the memory data returns, the block goes to the upper cache and then re-enters the set as an ordinary tag-checked write, because the set may have changed in the meantime.

Top module: `cc_chan_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `set_cmd_valid`, `mem_rd_valid`, `mem_wr_valid` and `up_rsp_valid` are 0.
- R2: `set_cmd_kind` is encoded as 0 = tag-checked read, 1 = tag-checked write, 2 = eviction read at a given way with no tag check, 3 = fill write at a given way with no tag check. `set_cmd_addr` is always the requested block address.
- R3: New requests reach `set_cmd` in the order they were accepted.
- R4: When a read's set response has hit = 1, its response data appears on `up_rsp` with the request address, and main memory is not accessed.
- R5: When a read's set response has hit = 0, a main-memory read for the address is issued. When its data returns, that data appears on `up_rsp` and then as a kind-1 write command for the same address.
- R6: An accepted write-back produces a kind-1 command that carries the request data.
- R7: A kind-1 response with hit = 1, or with dirty = 0, ends the transaction. No further command, memory access or upper response occurs for that block.
- R8: A kind-1 response with hit = 0 and dirty = 1 produces a kind-2 command whose way is `set_rsp_way`.
- R9: A kind-2 response produces a main-memory write of `set_rsp_addr`/`set_rsp_data`. After that write is accepted, a kind-3 command follows that carries the saved way and the pending block data.
- R10: Each block in flight holds an ID in [0, NSLOT) that no other block in flight holds. All later commands and memory reads for it carry that ID, and responses are routed by ID in any order.
- R11: At most NSLOT requests are in flight. `req_ready` is 0 while all slots are busy and 1 once all have completed.
- R12: The queue never overflows, and `mem_rd_valid`, `mem_wr_valid` and `up_rsp_valid` stay high until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Upper-cache request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_is_wr | input | 1 | 1 = write-back, 0 = read |
| req_addr | input | ADDR_W | Block address |
| req_data | input | BLK_W | Write-back block |
| set_cmd_valid | output | 1 | Set command present |
| set_cmd_ready | input | 1 | Set side takes the command |
| set_cmd_kind | output | 2 | Transaction kind (R2) |
| set_cmd_id | output | ID_W | Transaction ID |
| set_cmd_addr | output | ADDR_W | Block address |
| set_cmd_way | output | WAY_W | Way for kinds 2 and 3 |
| set_cmd_data | output | BLK_W | Block for kinds 1 and 3 |
| set_rsp_valid | input | 1 | Set response present |
| set_rsp_id | input | ID_W | ID of the answered command |
| set_rsp_hit | input | 1 | Tag matched |
| set_rsp_dirty | input | 1 | Replacement candidate is dirty |
| set_rsp_way | input | WAY_W | Victim way |
| set_rsp_addr | input | ADDR_W | Evicted block address |
| set_rsp_data | input | BLK_W | Read or evicted block |
| mem_rd_valid | output | 1 | Main-memory read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_id | output | ID_W | ID of the read |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_ret_valid | input | 1 | Memory read data present |
| mem_ret_id | input | ID_W | ID of returned data |
| mem_ret_data | input | BLK_W | Returned block |
| mem_wr_valid | output | 1 | Main-memory write request |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_addr | output | ADDR_W | Evicted block address |
| mem_wr_data | output | BLK_W | Evicted block |
| up_rsp_valid | output | 1 | Read data for the upper cache |
| up_rsp_ready | input | 1 | Upper cache takes it |
| up_rsp_addr | output | ADDR_W | Block address |
| up_rsp_data | output | BLK_W | Block data |

## Verification
The hardest situation to reach is the full eviction chain: miss, dirty, eviction read, memory write, fill. It has to run for several blocks at once while other slots are at other steps and the memory returns out of order. To reach it, the bench plays the set and the memory. It picks each response outcome at random, delays responses and ready signals at random, and returns memory data in random order. A stalled opening phase, with every ready low and no responses, fills all slots so the back-pressure limit and the queue order can be observed.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        TK_READ  = 2'd0,
        TK_WRITE = 2'd1,
        TK_DRD   = 2'd2,
        TK_FILL  = 2'd3
    } txn_kind_e;

    typedef enum logic [3:0] {
        SL_FREE, SL_WAIT, SL_UP_HIT, SL_MEM_RD, SL_MEM_WAIT,
        SL_UP_FILL, SL_PUSH_WR, SL_PUSH_DR, SL_MEM_WR, SL_PUSH_FW
    } slot_st_e;

    function automatic txn_kind_e follow_kind(input slot_st_e s);
        case (s)
            SL_PUSH_DR: return TK_DRD;
            SL_PUSH_FW: return TK_FILL;
            default:    return TK_WRITE;
        endcase
    endfunction
endpackage

// File: rtl/cc_pick.sv
module cc_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cc_fifo.sv
module cc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    logic [W-1:0] mem [DEPTH];
    ptr_t p_d, p_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (push) p_d.wp = step(p_q.wp);
        if (pop)  p_d.rp = step(p_q.rp);
        p_d.cnt = p_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[p_q.wp] <= din;
    end

    assign dout  = mem[p_q.rp];
    assign count = p_q.cnt;
    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/cc_chan_ctrl.sv
module cc_chan_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 512,
    parameter int WAY_W  = 7,
    parameter int NSLOT  = 8,
    parameter int QDEPTH = 64,
    parameter int ID_W   = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BLK_W-1:0]  req_data,
    output logic              set_cmd_valid,
    input  logic              set_cmd_ready,
    output logic [1:0]        set_cmd_kind,
    output logic [ID_W-1:0]   set_cmd_id,
    output logic [ADDR_W-1:0] set_cmd_addr,
    output logic [WAY_W-1:0]  set_cmd_way,
    output logic [BLK_W-1:0]  set_cmd_data,
    input  logic              set_rsp_valid,
    input  logic [ID_W-1:0]   set_rsp_id,
    input  logic              set_rsp_hit,
    input  logic              set_rsp_dirty,
    input  logic [WAY_W-1:0]  set_rsp_way,
    input  logic [ADDR_W-1:0] set_rsp_addr,
    input  logic [BLK_W-1:0]  set_rsp_data,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ID_W-1:0]   mem_rd_id,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_ret_valid,
    input  logic [ID_W-1:0]   mem_ret_id,
    input  logic [BLK_W-1:0]  mem_ret_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BLK_W-1:0]  mem_wr_data,
    output logic              up_rsp_valid,
    input  logic              up_rsp_ready,
    output logic [ADDR_W-1:0] up_rsp_addr,
    output logic [BLK_W-1:0]  up_rsp_data
);
    localparam int QE_W  = 2 + ID_W;
    localparam int CNT_W = $clog2(QDEPTH + 1);

    typedef struct packed {
        slot_st_e          st;
        txn_kind_e         op;
        logic [ADDR_W-1:0] addr;
        logic [WAY_W-1:0]  way;
        logic [BLK_W-1:0]  data;
        logic [ADDR_W-1:0] vaddr;
        logic [BLK_W-1:0]  vdata;
    } slot_t;

    typedef struct packed {
        slot_t [NSLOT-1:0] slot;
    } state_t;

    state_t st_d, st_q;

    logic [NSLOT-1:0] free_v, push_v, mrd_v, mwr_v, up_v;
    logic             free_any, push_any, mrd_any, mwr_any, up_any;
    logic [ID_W-1:0]  free_idx, push_idx, mrd_idx, mwr_idx, up_idx;

    logic              q_push, q_pop, q_empty, q_full;
    logic [QE_W-1:0]   q_din, q_dout;
    logic [CNT_W-1:0]  q_count;

    for (genvar i = 0; i < NSLOT; i++) begin : g_flag
        assign free_v[i] = (st_q.slot[i].st == SL_FREE);
        assign push_v[i] = (st_q.slot[i].st == SL_PUSH_WR) ||
                           (st_q.slot[i].st == SL_PUSH_DR) ||
                           (st_q.slot[i].st == SL_PUSH_FW);
        assign mrd_v[i]  = (st_q.slot[i].st == SL_MEM_RD);
        assign mwr_v[i]  = (st_q.slot[i].st == SL_MEM_WR);
        assign up_v[i]   = (st_q.slot[i].st == SL_UP_HIT) ||
                           (st_q.slot[i].st == SL_UP_FILL);
    end

    cc_pick #(.N(NSLOT), .IW(ID_W)) u_pk_free (.req(free_v), .any(free_any), .idx(free_idx));
    cc_pick #(.N(NSLOT), .IW(ID_W)) u_pk_push (.req(push_v), .any(push_any), .idx(push_idx));
    cc_pick #(.N(NSLOT), .IW(ID_W)) u_pk_mrd  (.req(mrd_v),  .any(mrd_any),  .idx(mrd_idx));
    cc_pick #(.N(NSLOT), .IW(ID_W)) u_pk_mwr  (.req(mwr_v),  .any(mwr_any),  .idx(mwr_idx));
    cc_pick #(.N(NSLOT), .IW(ID_W)) u_pk_up   (.req(up_v),   .any(up_any),   .idx(up_idx));

    cc_fifo #(.W(QE_W), .DEPTH(QDEPTH), .CW(CNT_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
        .dout(q_dout), .empty(q_empty), .full(q_full), .count(q_count)
    );

    // issue side: head of the in-order queue, fields fetched from its slot
    assign set_cmd_valid = !q_empty;
    assign q_pop         = set_cmd_valid && set_cmd_ready;
    assign set_cmd_kind  = q_dout[QE_W-1 -: 2];
    assign set_cmd_id    = q_dout[ID_W-1:0];
    assign set_cmd_addr  = st_q.slot[set_cmd_id].addr;
    assign set_cmd_way   = st_q.slot[set_cmd_id].way;
    assign set_cmd_data  = st_q.slot[set_cmd_id].data;

    assign mem_rd_valid = mrd_any;
    assign mem_rd_id    = mrd_idx;
    assign mem_rd_addr  = st_q.slot[mrd_idx].addr;

    assign mem_wr_valid = mwr_any;
    assign mem_wr_addr  = st_q.slot[mwr_idx].vaddr;
    assign mem_wr_data  = st_q.slot[mwr_idx].vdata;

    assign up_rsp_valid = up_any;
    assign up_rsp_addr  = st_q.slot[up_idx].addr;
    assign up_rsp_data  = st_q.slot[up_idx].data;

    // follow-up pushes win the queue port; new work waits for a quiet cycle
    assign req_ready = free_any && !push_any && !q_full;

    always_comb begin
        st_d   = st_q;
        q_push = 1'b0;
        q_din  = '0;

        if (push_any) begin
            q_push = 1'b1;
            q_din  = {follow_kind(st_q.slot[push_idx].st), push_idx};
            st_d.slot[push_idx].op = follow_kind(st_q.slot[push_idx].st);
            st_d.slot[push_idx].st = SL_WAIT;
        end else if (req_valid && req_ready) begin
            q_push = 1'b1;
            q_din  = {(req_is_wr ? TK_WRITE : TK_READ), free_idx};
            st_d.slot[free_idx].op   = req_is_wr ? TK_WRITE : TK_READ;
            st_d.slot[free_idx].st   = SL_WAIT;
            st_d.slot[free_idx].addr = req_addr;
            st_d.slot[free_idx].data = req_data;
        end

        if (set_rsp_valid) begin
            case (st_q.slot[set_rsp_id].op)
                TK_READ: begin
                    if (set_rsp_hit) begin
                        st_d.slot[set_rsp_id].data = set_rsp_data;
                        st_d.slot[set_rsp_id].st   = SL_UP_HIT;
                    end else begin
                        st_d.slot[set_rsp_id].st   = SL_MEM_RD;
                    end
                end
                TK_WRITE: begin
                    if (set_rsp_hit || !set_rsp_dirty) begin
                        st_d.slot[set_rsp_id].st  = SL_FREE;
                    end else begin
                        st_d.slot[set_rsp_id].way = set_rsp_way;
                        st_d.slot[set_rsp_id].st  = SL_PUSH_DR;
                    end
                end
                TK_DRD: begin
                    st_d.slot[set_rsp_id].vaddr = set_rsp_addr;
                    st_d.slot[set_rsp_id].vdata = set_rsp_data;
                    st_d.slot[set_rsp_id].st    = SL_MEM_WR;
                end
                default: st_d.slot[set_rsp_id].st = SL_FREE;
            endcase
        end

        if (mem_ret_valid) begin
            st_d.slot[mem_ret_id].data = mem_ret_data;
            st_d.slot[mem_ret_id].st   = SL_UP_FILL;
        end

        if (mem_rd_valid && mem_rd_ready) st_d.slot[mrd_idx].st = SL_MEM_WAIT;
        if (mem_wr_valid && mem_wr_ready) st_d.slot[mwr_idx].st = SL_PUSH_FW;
        if (up_rsp_valid && up_rsp_ready) begin
            st_d.slot[up_idx].st = (st_q.slot[up_idx].st == SL_UP_HIT) ? SL_FREE : SL_PUSH_WR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cc_chan_ctrl_chk.sv
module cc_chan_ctrl_chk #(
    parameter int NSLOT  = 8,
    parameter int QDEPTH = 64,
    parameter int ID_W   = 3,
    parameter int CNT_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] q_count,
    input logic             q_push,
    input logic             req_ready,
    input logic             set_cmd_valid,
    input logic             set_cmd_ready,
    input logic [1:0]       set_cmd_kind,
    input logic [ID_W-1:0]  set_cmd_id,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic             mem_wr_valid,
    input logic             mem_wr_ready,
    input logic             up_rsp_valid,
    input logic             up_rsp_ready
);
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (q_count < CNT_W'(QDEPTH)));

    a_r11_entries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(NSLOT));

    a_r11_full_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(QDEPTH)) |-> !req_ready);

    a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cmd_valid && !set_cmd_ready) |=>
            (set_cmd_valid && $stable(set_cmd_kind) && $stable(set_cmd_id)));

    a_r12_memrd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid);

    a_r12_memwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> mem_wr_valid);

    a_r12_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !up_rsp_ready) |=> up_rsp_valid);
endmodule

bind cc_chan_ctrl cc_chan_ctrl_chk #(
    .NSLOT(NSLOT), .QDEPTH(QDEPTH), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .q_count(q_count), .q_push(q_push),
    .req_ready(req_ready), .set_cmd_valid(set_cmd_valid),
    .set_cmd_ready(set_cmd_ready), .set_cmd_kind(set_cmd_kind),
    .set_cmd_id(set_cmd_id), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .up_rsp_valid(up_rsp_valid),
    .up_rsp_ready(up_rsp_ready)
);

// File: tb/cc_chan_ctrl_test.sv
module cc_chan_ctrl_test;
    localparam int AW = 32, BW = 512, WW = 7, NS = 8, QD = 64, IW = 3;
    localparam int NK = 512, NREQ = 300;
    localparam logic [31:0] VOFF = 32'h0010_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_is_wr = 0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_data = '0;
    logic req_ready;
    logic set_cmd_valid, set_cmd_ready = 0;
    logic [1:0] set_cmd_kind;
    logic [IW-1:0] set_cmd_id;
    logic [AW-1:0] set_cmd_addr;
    logic [WW-1:0] set_cmd_way;
    logic [BW-1:0] set_cmd_data;
    logic set_rsp_valid = 0, set_rsp_hit = 0, set_rsp_dirty = 0;
    logic [IW-1:0] set_rsp_id = '0;
    logic [WW-1:0] set_rsp_way = '0;
    logic [AW-1:0] set_rsp_addr = '0;
    logic [BW-1:0] set_rsp_data = '0;
    logic mem_rd_valid, mem_rd_ready = 0;
    logic [IW-1:0] mem_rd_id;
    logic [AW-1:0] mem_rd_addr;
    logic mem_ret_valid = 0;
    logic [IW-1:0] mem_ret_id = '0;
    logic [BW-1:0] mem_ret_data = '0;
    logic mem_wr_valid, mem_wr_ready = 0;
    logic [AW-1:0] mem_wr_addr;
    logic [BW-1:0] mem_wr_data;
    logic up_rsp_valid, up_rsp_ready = 0;
    logic [AW-1:0] up_rsp_addr;
    logic [BW-1:0] up_rsp_data;

    always #4 clk = ~clk;

    cc_chan_ctrl #(.ADDR_W(AW), .BLK_W(BW), .WAY_W(WW), .NSLOT(NS), .QDEPTH(QD)) uut (.*);

    // bench model, keyed by block address
    int ph [NK];
    int tid [NK];
    int wy [NK];
    logic [BW-1:0] dw [NK], dh [NK], dv [NK];
    int idowner [NS];
    typedef struct { int k; int id; int kind; int outc; } rsp_t;
    typedef struct { int k; int id; } mrd_t;
    rsp_t sq[$];
    mrd_t mq[$];
    int order_q[$];
    int nchk = 0, nerr = 0, acc = 0, done_cnt = 0, next_k = 0;
    bit req_fire = 0;

    function automatic logic [BW-1:0] rnd_blk();
        logic [BW-1:0] b;
        for (int j = 0; j < BW / 32; j++) b[j*32 +: 32] = $urandom;
        return b;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic fresh_id(input int k, input int id);
        int first;
        chk(idowner[id] == -1, "R10", "ID already in use", 64'(id), 64'(id));
        idowner[id] = k;
        tid[k] = id;
        first = (order_q.size() > 0) ? order_q.pop_front() : -1;
        chk(first == k, "R3", "first command order", 64'(k), 64'(first));
    endtask

    task automatic release_id(input int k);
        if (tid[k] >= 0 && tid[k] < NS) idowner[tid[k]] = -1;
        ph[k] = 0;
        done_cnt++;
    endtask

    task automatic on_cmd();
        int k, kind, id, o;
        k = int'(set_cmd_addr); kind = int'(set_cmd_kind); id = int'(set_cmd_id);
        if (k >= NK) begin chk(0, "R2", "cmd address", 64'(k), 64'(0)); return; end
        case (ph[k])
            1: begin
                chk(kind == 0, "R2", "read kind", 64'(kind), 64'd0);
                fresh_id(k, id);
                o = $urandom % 2;
                if (o == 1) begin dh[k] = rnd_blk(); ph[k] = 2; end else ph[k] = 3;
                sq.push_back('{k, id, 0, o});
            end
            6: begin
                chk(kind == 1, "R2", "write kind", 64'(kind), 64'd1);
                if (tid[k] == -1) begin
                    fresh_id(k, id);
                    chk(set_cmd_data == dw[k], "R6", "write-back data", set_cmd_data[63:0], dw[k][63:0]);
                end else begin
                    chk(id == tid[k], "R10", "write id", 64'(id), 64'(tid[k]));
                    chk(set_cmd_data == dw[k], "R5", "refill write data", set_cmd_data[63:0], dw[k][63:0]);
                end
                o = $urandom % 3;
                sq.push_back('{k, id, 1, o});
                if (o == 2) begin wy[k] = $urandom % 128; ph[k] = 7; end
                else release_id(k);
            end
            7: begin
                chk(kind == 2, "R8", "evict kind", 64'(kind), 64'd2);
                chk(int'(set_cmd_way) == wy[k], "R8", "evict way", 64'(set_cmd_way), 64'(wy[k]));
                chk(id == tid[k], "R10", "evict id", 64'(id), 64'(tid[k]));
                dv[k] = rnd_blk();
                sq.push_back('{k, id, 2, 0});
                ph[k] = 8;
            end
            9: begin
                chk(kind == 3, "R9", "fill kind", 64'(kind), 64'd3);
                chk(int'(set_cmd_way) == wy[k], "R9", "fill way", 64'(set_cmd_way), 64'(wy[k]));
                chk(set_cmd_data == dw[k], "R9", "fill data", set_cmd_data[63:0], dw[k][63:0]);
                chk(id == tid[k], "R10", "fill id", 64'(id), 64'(tid[k]));
                sq.push_back('{k, id, 3, 0});
                release_id(k);
            end
            8: chk(0, "R9", "fill before memory write", 64'(kind), 64'(ph[k]));
            default: chk(0, "R7", "unexpected set command", 64'(kind), 64'(ph[k]));
        endcase
    endtask

    task automatic drive_rsp();
        rsp_t r;
        set_rsp_valid = 0;
        if (sq.size() > 0 && ($urandom % 2) == 1) begin
            r = sq.pop_front();
            set_rsp_valid = 1; set_rsp_id = IW'(r.id);
            set_rsp_hit = 0; set_rsp_dirty = 0; set_rsp_way = '0;
            set_rsp_addr = '0; set_rsp_data = rnd_blk();
            case (r.kind)
                0: begin set_rsp_hit = (r.outc == 1); if (r.outc == 1) set_rsp_data = dh[r.k]; end
                1: begin
                    set_rsp_hit   = (r.outc == 0);
                    set_rsp_dirty = (r.outc == 2) ? 1'b1 : ((r.outc == 0) ? 1'($urandom % 2) : 1'b0);
                    if (r.outc == 2) set_rsp_way = WW'(wy[r.k]);
                end
                2: begin set_rsp_addr = AW'(r.k) + VOFF; set_rsp_data = dv[r.k]; end
                default: set_rsp_hit = 1;
            endcase
        end
    endtask

    task automatic drive_mem();
        mrd_t m;
        int i;
        mem_ret_valid = 0;
        if (mq.size() > 0 && ($urandom % 2) == 1) begin
            i = $urandom % mq.size();
            m = mq[i];
            mq.delete(i);
            dw[m.k] = rnd_blk();
            mem_ret_valid = 1; mem_ret_id = IW'(m.id); mem_ret_data = dw[m.k];
            ph[m.k] = 5;
        end
    endtask

    task automatic tick(input bit allow_req, input bit stall);
        int k;
        @(negedge clk);
        if (req_fire) begin req_valid = 0; req_fire = 0; end
        set_cmd_ready = stall ? 1'b0 : 1'(($urandom % 4) != 0);
        mem_rd_ready  = stall ? 1'b0 : 1'($urandom % 2);
        mem_wr_ready  = stall ? 1'b0 : 1'($urandom % 2);
        up_rsp_ready  = stall ? 1'b0 : 1'($urandom % 2);
        if (stall) begin set_rsp_valid = 0; mem_ret_valid = 0; end
        else begin drive_rsp(); drive_mem(); end
        if (set_cmd_valid && set_cmd_ready) on_cmd();
        if (mem_rd_valid && mem_rd_ready) begin
            k = int'(mem_rd_addr);
            if (k < NK && ph[k] == 3) begin
                chk(int'(mem_rd_id) == tid[k], "R10", "memory read id", 64'(mem_rd_id), 64'(tid[k]));
                mq.push_back('{k, int'(mem_rd_id)});
                ph[k] = 4;
            end else chk(0, "R4", "unexpected memory read", 64'(mem_rd_addr), 64'(0));
        end
        if (mem_wr_valid && mem_wr_ready) begin
            k = int'(mem_wr_addr - VOFF);
            if (k >= 0 && k < NK && ph[k] == 8) begin
                chk(mem_wr_data == dv[k], "R9", "evicted data", mem_wr_data[63:0], dv[k][63:0]);
                ph[k] = 9;
            end else chk(0, "R9", "unexpected memory write", 64'(mem_wr_addr), 64'(0));
        end
        if (up_rsp_valid && up_rsp_ready) begin
            k = int'(up_rsp_addr);
            if (k < NK && ph[k] == 2) begin
                chk(up_rsp_data == dh[k], "R4", "hit data upward", up_rsp_data[63:0], dh[k][63:0]);
                release_id(k);
            end else if (k < NK && ph[k] == 5) begin
                chk(up_rsp_data == dw[k], "R5", "miss data upward", up_rsp_data[63:0], dw[k][63:0]);
                ph[k] = 6;
            end else chk(0, "R4", "unexpected upper response", 64'(up_rsp_addr), 64'(0));
        end
        if (!req_valid && allow_req && next_k < NREQ && ($urandom % 2) == 1) begin
            req_valid = 1; req_addr = AW'(next_k); req_is_wr = 1'($urandom % 2);
            req_data = rnd_blk();
            next_k++;
        end
        if (req_valid && req_ready) begin
            k = int'(req_addr);
            tid[k] = -1;
            if (req_is_wr) begin dw[k] = req_data; ph[k] = 6; end else ph[k] = 1;
            order_q.push_back(k);
            acc++;
            req_fire = 1;
        end
    endtask

    initial begin
        int guard;
        void'($urandom(32'h5eed));
        for (int i = 0; i < NK; i++) begin ph[i] = 0; tid[i] = -1; wy[i] = 0; end
        for (int i = 0; i < NS; i++) idowner[i] = -1;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_ready == 1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
        chk({set_cmd_valid, mem_rd_valid, mem_wr_valid, up_rsp_valid} == 4'b0, "R1",
            "valids in reset", 64'({set_cmd_valid, mem_rd_valid, mem_wr_valid, up_rsp_valid}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && !set_cmd_valid && !up_rsp_valid, "R1", "after reset",
            64'({req_ready, set_cmd_valid, up_rsp_valid}), 64'b100);
        // R11: stalled sink fills every slot, then requests are held off
        for (int i = 0; i < 24; i++) tick(1, 1);
        chk(acc == NS, "R11", "accepted while stalled", 64'(acc), 64'(NS));
        chk(req_ready == 0, "R11", "req_ready with all slots busy", 64'(req_ready), 64'd0);
        // random traffic; R3 order checked on every first command
        guard = 0;
        while ((next_k < NREQ || done_cnt < acc || req_valid || sq.size() > 0) && guard < 150000) begin
            tick(1, 0);
            guard++;
        end
        chk(guard < 150000, "R7", "watchdog", 64'(guard), 64'd150000);
        for (int i = 0; i < 30; i++) tick(0, 0);
        chk(done_cnt == NREQ, "R7", "completed blocks", 64'(done_cnt), 64'(NREQ));
        chk(req_ready == 1, "R11", "req_ready after drain", 64'(req_ready), 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule